// File: doc/BRIEF.md
# SPI Master Word Shifter

This block is the shifting core of an SPI master. A client presents a format word, a per-word control half-word and up to sixteen bits of transmit data, then pulses `start`. The engine drives the serial clock, the outgoing data line and a set of active-low chip selects, samples the incoming line, and returns the received bits right-aligned together with a single-cycle completion pulse.

The format word sets the clock divider, the character length, clock polarity, the edge relation between data and clock, bit order, and an optional parity bit. The control half-word picks which chip selects are active during the word. It also sets whether they stay active once the word ends and whether an idle gap follows the word. A loopback input makes the engine receive its own outgoing bits in place of the input pin.

Top module: `wse_spi_engine`

## Requirements
- R1: After reset `cs_n` is all ones, and `mosi`, `word_done`, `busy` and `rx_word` are zero.
- R2: Each bit occupies P functional clock cycles, where P is the prescale field fmt_cfg[15:8] plus one, and a field of zero is treated as one (P = 2). Within a bit, the clock holds its first level for floor(P/2) cycles and its second level for the rest.
- R3: fmt_cfg[17] gives the idle clock level: high when set, low when clear. `sclk` sits at this level outside the bit periods, including any gap.
- R4: With fmt_cfg[16] set, a bit period starts at the idle level and the leading edge falls mid-bit. With it clear, the leading edge coincides with the start of the bit period. In both cases the input is sampled on the edge that falls floor(P/2) cycles into the bit.
- R5: The character length L is fmt_cfg[4:0], raised to 2 when below 2 and limited to 16 when above 16. Bits are sent most significant first, or least significant first when fmt_cfg[20] is set. `mosi` changes only at bit-period boundaries and is 0 outside a word.
- R6: With fmt_cfg[22] set, one parity bit follows the L data bits. It is odd parity over the data bits when fmt_cfg[23] is set and even parity otherwise. The received parity bit is not placed in `rx_word`.
- R7: During a word, `cs_n` equals ctrl_cfg[7:0], where a 0 bit drives its line low. After the word it keeps that pattern when ctrl_cfg[12] is set and returns to all ones when it is clear.
- R8: With ctrl_cfg[10] set, `busy` stays high for (fmt_cfg[29:24] + 2) * P cycles after the last bit period, with `sclk` idle. Without it, `busy` falls in the cycle after the last bit period.
- R9: `word_done` is high for exactly one cycle, the cycle after the last bit period. In that same cycle `rx_word` shows the L received data bits right-aligned in the original bit order, with zeros above bit L-1.
- R10: While `loopback` is high, the received bits are the bits the engine itself drives on `mosi`, and `miso` has no effect.
- R11: A `start` pulse while `busy` is high is ignored, and the word in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a word when not busy |
| fmt_cfg | input | 32 | Format word: divider, length, polarity, phase, order, parity, gap |
| ctrl_cfg | input | 16 | Per-word control: chip-select pattern, gap enable, hold |
| tx_word | input | DATA_W | Data to send, right-aligned |
| loopback | input | 1 | Receive own output instead of `miso` |
| miso | input | 1 | Serial input from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output to the peripheral |
| cs_n | output | NCS | Active-low chip selects |
| rx_word | output | DATA_W | Received data, right-aligned |
| word_done | output | 1 | One-cycle pulse at the end of a word |
| busy | output | 1 | Word or gap in progress |

## Verification
A wrong period counter or bit index becomes visible on `sclk` or `mosi` within one bit period, because the bench predicts both pins on every cycle. A wrong latched setting usually shows in the first cycle after `start`, as a wrong idle level, chip-select pattern or first bit. A fault in the receive placement or parity selection only shows at the completion pulse, when `rx_word` is compared with the expected value. A broken gap counter shows as `busy` falling early or late by whole bit periods.

// File: rtl/wse_pkg.sv
package wse_pkg;
  // Field positions inside the format word
  localparam int FMT_LEN_LSB      = 0;
  localparam int FMT_LEN_W        = 5;
  localparam int FMT_PRE_LSB      = 8;
  localparam int FMT_PHASE_BIT    = 16;
  localparam int FMT_POL_BIT      = 17;
  localparam int FMT_LSBF_BIT     = 20;
  localparam int FMT_PAR_EN_BIT   = 22;
  localparam int FMT_PAR_ODD_BIT  = 23;
  localparam int FMT_GAP_LSB      = 24;
  // Field positions inside the per-word control half
  localparam int CTL_CS_LSB       = 0;
  localparam int CTL_DLY_BIT      = 10;
  localparam int CTL_HOLD_BIT     = 12;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/wse_fmt_decode.sv
module wse_fmt_decode
  import wse_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8,
  parameter int GAP_W  = 6,
  parameter int NCS    = 8,
  parameter int LW     = 5,
  parameter int PW     = 9
) (
  input  logic [31:0]      fmt_cfg,
  input  logic [15:0]      ctrl_cfg,
  output logic [PW-1:0]    period,
  output logic [PW-1:0]    half,
  output logic [LW-1:0]    len,
  output logic [LW-1:0]    nbits,
  output logic             cpol,
  output logic             lead,
  output logic             lsbf,
  output logic             par_en,
  output logic             par_odd,
  output logic             dly,
  output logic             hold,
  output logic [GAP_W-1:0] gap,
  output logic [NCS-1:0]   cs_pat
);
  logic [FMT_LEN_W-1:0] raw_len;
  logic [PRE_W-1:0]     pre;
  logic                 unused_cfg;

  assign unused_cfg = ^{fmt_cfg, ctrl_cfg};

  always_comb begin
    raw_len = fmt_cfg[FMT_LEN_LSB +: FMT_LEN_W];
    if (raw_len < FMT_LEN_W'(2))
      len = LW'(2);
    else if (int'(raw_len) > DATA_W)
      len = LW'(DATA_W);
    else
      len = LW'(raw_len);

    pre    = fmt_cfg[FMT_PRE_LSB +: PRE_W];
    period = (pre == '0) ? PW'(2) : (PW'(pre) + PW'(1));
    half   = period >> 1;

    cpol    = fmt_cfg[FMT_POL_BIT];
    lead    = fmt_cfg[FMT_PHASE_BIT] ? cpol : ~cpol;
    lsbf    = fmt_cfg[FMT_LSBF_BIT];
    par_en  = fmt_cfg[FMT_PAR_EN_BIT];
    par_odd = fmt_cfg[FMT_PAR_ODD_BIT];
    nbits   = len + LW'(par_en);
    gap     = fmt_cfg[FMT_GAP_LSB +: GAP_W];
    dly     = ctrl_cfg[CTL_DLY_BIT];
    hold    = ctrl_cfg[CTL_HOLD_BIT];
    cs_pat  = ctrl_cfg[CTL_CS_LSB +: NCS];
  end
endmodule

// File: rtl/wse_bit_timer.sv
module wse_bit_timer #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic [PW-1:0] period,
  input  logic [PW-1:0] half,
  output logic [PW-1:0] pos,
  output logic          pos_last,
  output logic          mid_hit
);
  assign pos_last = (pos == (period - PW'(1)));
  assign mid_hit  = (pos == (half - PW'(1)));

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (load)
      pos <= '0;
    else if (run)
      pos <= pos_last ? '0 : (pos + PW'(1));
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (pos < period));
endmodule

// File: rtl/wse_shift_path.sv
module wse_shift_path #(
  parameter int DATA_W = 16,
  parameter int LW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sel_tx,
  input  logic [LW-1:0]     sel_len,
  input  logic              sel_lsbf,
  input  logic              sel_odd,
  input  logic [LW-1:0]     sel_idx,
  output logic              tx_bit,
  input  logic              clr,
  input  logic              cap,
  input  logic              cap_bit,
  input  logic [LW-1:0]     cap_idx,
  input  logic [LW-1:0]     cap_len,
  input  logic              cap_lsbf,
  output logic [DATA_W-1:0] rx_acc
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] mask;
  logic              par_bit;
  logic [LW-1:0]     rev_t;
  logic [LW-1:0]     rev_r;
  logic [IW-1:0]     pick_t;
  logic [IW-1:0]     pick_r;

  always_comb begin
    for (int j = 0; j < DATA_W; j++)
      mask[j] = (LW'(j) < sel_len);
    par_bit = sel_odd ^ (^(sel_tx & mask));
    rev_t   = sel_len - LW'(1) - sel_idx;
    pick_t  = sel_lsbf ? IW'(sel_idx) : IW'(rev_t);
    tx_bit  = (sel_idx < sel_len) ? sel_tx[pick_t] : par_bit;

    rev_r   = cap_len - LW'(1) - cap_idx;
    pick_r  = cap_lsbf ? IW'(cap_idx) : IW'(rev_r);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      rx_acc <= '0;
    else if (cap && (cap_idx < cap_len))
      rx_acc[pick_r] <= cap_bit;
  end

  // R6: only data slots and the one parity slot are ever sampled
  cap_idx_chk: assert property (@(posedge clk) disable iff (rst)
    cap |-> (cap_idx <= cap_len));
endmodule

// File: rtl/wse_spi_engine.sv
module wse_spi_engine
  import wse_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NCS    = 8,
  parameter int PRE_W  = 8,
  parameter int GAP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       fmt_cfg,
  input  logic [15:0]       ctrl_cfg,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              loopback,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    cs_n,
  output logic [DATA_W-1:0] rx_word,
  output logic              word_done,
  output logic              busy
);
  localparam int LW = $clog2(DATA_W + 2);
  localparam int PW = PRE_W + 1;

  // live decode
  logic [PW-1:0]    d_period, d_half;
  logic [LW-1:0]    d_len, d_nbits;
  logic             d_cpol, d_lead, d_lsbf, d_par_en, d_par_odd, d_dly, d_hold;
  logic [GAP_W-1:0] d_gap;
  logic [NCS-1:0]   d_cs;

  // settings held for the word in flight
  logic [PW-1:0]     period_q, half_q;
  logic [LW-1:0]     len_q, nbits_q;
  logic              cpol_q, lead_q, lsbf_q, odd_q, dly_q, hold_q;
  logic [GAP_W-1:0]  gap_q;
  logic [NCS-1:0]    cs_q;
  logic [DATA_W-1:0] tx_q;

  seq_state_e        st;
  logic [LW-1:0]     bidx;
  logic [GAP_W:0]    gcnt;
  logic [PW-1:0]     pos;
  logic              pos_last, mid_hit;
  logic              accept, end_word, gap_done, cap;
  logic              tx_bit;
  logic [DATA_W-1:0] rx_acc;
  logic [DATA_W-1:0] sel_tx;
  logic [LW-1:0]     sel_len, sel_idx;
  logic              sel_lsbf, sel_odd;
  logic              unused_dec;

  assign unused_dec = ^{d_par_en, pos};

  wse_fmt_decode #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .GAP_W(GAP_W), .NCS(NCS), .LW(LW), .PW(PW)
  ) u_dec (
    .fmt_cfg (fmt_cfg),
    .ctrl_cfg(ctrl_cfg),
    .period  (d_period),
    .half    (d_half),
    .len     (d_len),
    .nbits   (d_nbits),
    .cpol    (d_cpol),
    .lead    (d_lead),
    .lsbf    (d_lsbf),
    .par_en  (d_par_en),
    .par_odd (d_par_odd),
    .dly     (d_dly),
    .hold    (d_hold),
    .gap     (d_gap),
    .cs_pat  (d_cs)
  );

  assign accept   = (st == SEQ_IDLE) && start;
  assign end_word = (st == SEQ_SHIFT) && pos_last && (bidx == (nbits_q - LW'(1)));
  assign gap_done = (st == SEQ_GAP) && pos_last &&
                    (gcnt == ({1'b0, gap_q} + (GAP_W+1)'(1)));
  assign cap      = (st == SEQ_SHIFT) && mid_hit;
  assign busy     = (st != SEQ_IDLE);

  wse_bit_timer #(.PW(PW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .load    (accept),
    .period  (period_q),
    .half    (half_q),
    .pos     (pos),
    .pos_last(pos_last),
    .mid_hit (mid_hit)
  );

  // On the accepting edge the first bit comes from the live inputs
  assign sel_tx   = accept ? tx_word   : tx_q;
  assign sel_len  = accept ? d_len     : len_q;
  assign sel_lsbf = accept ? d_lsbf    : lsbf_q;
  assign sel_odd  = accept ? d_par_odd : odd_q;
  assign sel_idx  = accept ? '0        : (bidx + LW'(1));

  wse_shift_path #(.DATA_W(DATA_W), .LW(LW)) u_sp (
    .clk     (clk),
    .rst     (rst),
    .sel_tx  (sel_tx),
    .sel_len (sel_len),
    .sel_lsbf(sel_lsbf),
    .sel_odd (sel_odd),
    .sel_idx (sel_idx),
    .tx_bit  (tx_bit),
    .clr     (accept),
    .cap     (cap),
    .cap_bit (loopback ? mosi : miso),
    .cap_idx (bidx),
    .cap_len (len_q),
    .cap_lsbf(lsbf_q),
    .rx_acc  (rx_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SEQ_IDLE;
      bidx      <= '0;
      gcnt      <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      cs_n      <= '1;
      rx_word   <= '0;
      word_done <= 1'b0;
      period_q  <= PW'(2);
      half_q    <= PW'(1);
      len_q     <= LW'(2);
      nbits_q   <= LW'(2);
      cpol_q    <= 1'b0;
      lead_q    <= 1'b0;
      lsbf_q    <= 1'b0;
      odd_q     <= 1'b0;
      dly_q     <= 1'b0;
      hold_q    <= 1'b0;
      gap_q     <= '0;
      cs_q      <= '1;
      tx_q      <= '0;
    end else begin
      word_done <= 1'b0;
      unique case (st)
        SEQ_IDLE: begin
          sclk <= d_cpol;
          if (accept) begin
            st       <= SEQ_SHIFT;
            bidx     <= '0;
            sclk     <= d_lead;
            mosi     <= tx_bit;
            cs_n     <= d_cs;
            period_q <= d_period;
            half_q   <= d_half;
            len_q    <= d_len;
            nbits_q  <= d_nbits;
            cpol_q   <= d_cpol;
            lead_q   <= d_lead;
            lsbf_q   <= d_lsbf;
            odd_q    <= d_par_odd;
            dly_q    <= d_dly;
            hold_q   <= d_hold;
            gap_q    <= d_gap;
            cs_q     <= d_cs;
            tx_q     <= tx_word;
          end
        end
        SEQ_SHIFT: begin
          if (mid_hit)
            sclk <= ~lead_q;
          if (end_word) begin
            word_done <= 1'b1;
            rx_word   <= rx_acc;
            cs_n      <= hold_q ? cs_q : '1;
            sclk      <= cpol_q;
            mosi      <= 1'b0;
            gcnt      <= '0;
            st        <= dly_q ? SEQ_GAP : SEQ_IDLE;
          end else if (pos_last) begin
            bidx <= bidx + LW'(1);
            mosi <= tx_bit;
            sclk <= lead_q;
          end
        end
        SEQ_GAP: begin
          sclk <= cpol_q;
          if (gap_done)
            st <= SEQ_IDLE;
          else if (pos_last)
            gcnt <= gcnt + (GAP_W+1)'(1);
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);

  // R9
  rx_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |-> ((rx_word >> len_q) == '0));

  // R7
  cs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == SEQ_SHIFT) && $past(st == SEQ_SHIFT)) |-> $stable(cs_n));

  // R3
  gap_idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == SEQ_GAP) && $past(st == SEQ_GAP)) |-> (sclk == cpol_q));

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == SEQ_SHIFT) && $past(st == SEQ_SHIFT) && !$past(pos_last)) |-> $stable(mosi));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(tx_q));
endmodule

// File: tb/wse_spi_engine_tb_top.sv
module wse_spi_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] fmt_cfg;
  logic [15:0] ctrl_cfg;
  logic [15:0] tx_word;
  logic        loopback;
  logic        miso;
  logic        sclk;
  logic        mosi;
  logic [7:0]  cs_n;
  logic [15:0] rx_word;
  logic        word_done;
  logic        busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  wse_spi_engine dut_i (
    .clk(clk), .rst(rst), .start(start), .fmt_cfg(fmt_cfg), .ctrl_cfg(ctrl_cfg),
    .tx_word(tx_word), .loopback(loopback), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .rx_word(rx_word), .word_done(word_done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] mkfmt(input int pre, input int len, input bit phs,
                                         input bit pol, input bit lsbf, input bit pen,
                                         input bit podd, input int gap);
    logic [31:0] f;
    f = '0;
    f[4:0]   = len[4:0];
    f[15:8]  = pre[7:0];
    f[16]    = phs;
    f[17]    = pol;
    f[20]    = lsbf;
    f[22]    = pen;
    f[23]    = podd;
    f[29:24] = gap[5:0];
    return f;
  endfunction

  // Behavioural model: predicts every pin on every cycle of one word
  task automatic run_word(input logic [31:0] fmt, input logic [15:0] ctrl,
                          input logic [15:0] tx, input logic [15:0] mpat,
                          input bit lb, input bit poke);
    int pre, p, h1, l, n, g, slot, ps;
    bit cpol, phs, lsbf, pen, podd, hold, lead, e_sclk, pb;
    int bitv[17];
    int exp_rx, r;
    logic [7:0] pat;
    string tg;
    pre  = int'(fmt[15:8]);
    p    = (pre == 0) ? 2 : pre + 1;
    h1   = p / 2;
    l    = int'(fmt[4:0]);
    if (l < 2) l = 2;
    if (l > 16) l = 16;
    pen  = fmt[22];
    podd = fmt[23];
    n    = l + (pen ? 1 : 0);
    cpol = fmt[17];
    phs  = fmt[16];
    lsbf = fmt[20];
    hold = ctrl[12];
    pat  = ctrl[7:0];
    g    = ctrl[10] ? (int'(fmt[29:24]) + 2) * p : 0;
    lead = phs ? cpol : !cpol;
    pb   = podd;
    for (int i = 0; i < l; i++) begin
      bitv[i] = lsbf ? int'(tx[i]) : int'(tx[l-1-i]);
      pb ^= tx[i];
    end
    bitv[l] = int'(pb);
    exp_rx = 0;
    for (int i = 0; i < l; i++) begin
      r = lb ? bitv[i] : int'(mpat[i]);
      exp_rx |= r << (lsbf ? i : (l - 1 - i));
    end

    @(negedge clk);
    fmt_cfg  = fmt;
    ctrl_cfg = ctrl;
    tx_word  = tx;
    loopback = lb;
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= n * p + g; k++) begin
      tg = poke ? "R5 R11" : "R5";
      if (k < n * p) begin
        slot = k / p;
        ps   = k % p;
        e_sclk = (ps < h1) ? lead : !lead;
        chk(sclk == e_sclk, "R2 R4 sclk", int'(sclk), int'(e_sclk));
        chk(mosi == bitv[slot][0], tg, int'(mosi), bitv[slot]);
        chk(cs_n == pat, "R7 active", int'(cs_n), int'(pat));
        chk(busy == 1'b1, "R8 busy", int'(busy), 1);
        chk(word_done == 1'b0, "R9 done", int'(word_done), 0);
        if (ps == 0) miso = mpat[slot < 16 ? slot : 0];
      end else begin
        chk(sclk == cpol, "R3 idle", int'(sclk), int'(cpol));
        chk(mosi == 1'b0, "R5 idle", int'(mosi), 0);
        chk(cs_n == (hold ? pat : 8'hFF), "R7 after", int'(cs_n),
            int'(hold ? pat : 8'hFF));
        chk(word_done == (k == n * p), "R9 pulse", int'(word_done), int'(k == n * p));
        chk(busy == (k < n * p + g), "R8 gap", int'(busy), int'(k < n * p + g));
        if (k == n * p)
          chk(rx_word == exp_rx[15:0], lb ? "R10 R9 rx" : "R6 R9 rx",
              int'(rx_word), exp_rx);
      end
      if (poke && k == 3) begin
        start   = 1'b1;
        tx_word = ~tx;
      end else if (poke && k == 4) begin
        start   = 1'b0;
        tx_word = tx;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1; start = 1'b0; fmt_cfg = '0; ctrl_cfg = '0;
    tx_word = '0; loopback = 1'b0; miso = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 8'hFF, "R1 cs_n", int'(cs_n), 8'hFF);
    chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(word_done == 1'b0, "R1 done", int'(word_done), 0);
    chk(rx_word == 16'h0, "R1 rx", int'(rx_word), 0);

    // R2 R4 R5: 8 bits, MSB first, data before leading edge, P = 4
    run_word(mkfmt(3, 8, 1, 0, 0, 0, 0, 0), 16'h00FE, 16'h00A5, 16'h003C, 0, 0);
    // R3 R5 R7: 16 bits, LSB first, idle high, leading edge at bit start, hold
    run_word(mkfmt(1, 16, 0, 1, 1, 0, 0, 0), 16'h10FB, 16'hC3A1, 16'h5A0F, 0, 0);
    repeat (3) @(negedge clk);
    chk(cs_n == 8'hFB, "R7 held idle", int'(cs_n), 8'hFB);
    // R2 R5 R6: prescale 0 -> P = 2, length 1 -> 2, even parity
    run_word(mkfmt(0, 1, 0, 0, 0, 1, 0, 0), 16'h00EF, 16'h0003, 16'h0002, 0, 0);
    // R5 R6 R8: length 20 -> 16, odd parity, gap 5, P = 5
    run_word(mkfmt(4, 20, 1, 1, 0, 1, 1, 5), 16'h047F, 16'h9E37, 16'hFFFF, 0, 0);
    // R10 R11: loopback with a miso pattern that must be ignored, start poked mid-word
    run_word(mkfmt(6, 12, 1, 0, 0, 0, 0, 0), 16'h00F7, 16'h0B6D, 16'h0FFF, 1, 1);
    // R2 R8: largest prescale with longest gap
    run_word(mkfmt(255, 3, 0, 0, 0, 0, 0, 63), 16'h04BF, 16'h0005, 16'h0002, 0, 0);
    // R6 R7: even parity LSB first, hold then release
    run_word(mkfmt(2, 7, 1, 1, 1, 1, 0, 0), 16'h10DF, 16'h0059, 16'h0036, 0, 0);
    run_word(mkfmt(2, 9, 0, 0, 0, 0, 0, 2), 16'h047E, 16'h01C4, 16'h012B, 0, 0);
    finish_run();
  end
endmodule